// File: doc/BRIEF.md
# Privilege-Masked Interrupt Pending Unit

This block keeps the pending and enable flags for the interrupt sources of one hart that has user, supervisor and machine interrupts. Each privilege level owns a software, a timer and an external source. Status-level global enables are applied per privilege group: each one gates its group's three sources. When at least one source is pending, enabled and unmasked, the block raises an interrupt request and reports the cause number of the winning source.

Single-cycle strobes set or clear individual pending flags. A further strobe wipes the whole pending vector. Software reads both vectors as whole registers and can overwrite either one in a single cycle. The request and cause outputs are combinational from the stored flags and the current global enables. Trap entry, delegation and privilege comparison are handled outside this block.

Top module: `irq_pend_unit`

## Requirements
- R1: After reset, the pending vector and the enable vector both read as zero, and the request is low.
- R2: The vectors are 12 bits wide. Implemented sources sit at fixed positions: software at bits 0 (user), 1 (supervisor) and 3 (machine); timers at bits 4, 5 and 7; external sources at bits 8, 9 and 11. Bits 2, 6 and 10 always read as zero, whatever is written or posted to them.
- R3: The global mask is built per group. mGie unmasks bits 3, 7 and 11. sGie unmasks bits 1, 5 and 9. uGie unmasks bits 0, 4 and 8.
- R4: irqReq is high exactly when pending AND enable AND global mask is non-zero, evaluated combinationally from the current registers and gie inputs.
- R5: irqCause is the lowest bit index that is pending, enabled and unmasked. It is 0 when irqReq is low.
- R6: postVec bit n sets pending bit n and clrVec bit n clears it at the next clock edge. If both are set for the same bit in the same cycle, the bit ends up set.
- R7: clrAll zeroes the pending vector at the next edge, except for bits posted in the same cycle, which end up set.
- R8: pendWrEn replaces the pending vector with pendWrData, and enWrEn replaces the enable vector with enWrData. A post or clear strobe in the same cycle as a pending write is applied after the write, so the strobe decides its bit.
- R9: A source that is pending and enabled but whose group enable is low never raises irqReq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| postVec | input | 12 | Per-source set strobes for pending bits |
| clrVec | input | 12 | Per-source clear strobes for pending bits |
| clrAll | input | 1 | Clear the whole pending vector |
| pendWrEn | input | 1 | Write strobe for the pending vector |
| pendWrData | input | 12 | New pending vector value |
| enWrEn | input | 1 | Write strobe for the enable vector |
| enWrData | input | 12 | New enable vector value |
| uGie | input | 1 | User group global enable |
| sGie | input | 1 | Supervisor group global enable |
| mGie | input | 1 | Machine group global enable |
| pendRd | output | 12 | Current pending vector |
| enRd | output | 12 | Current enable vector |
| irqReq | output | 1 | Interrupt request |
| irqCause | output | 4 | Index of the selected source |

## Verification
The assertions require any strobe or write on the reserved positions to be harmless. They also require the gie inputs to be steady when the outputs are sampled, because request and cause follow them within the same cycle. The stimulus drives every input half a period before the active edge, so all inputs are settled when the design samples them. Random vectors deliberately include the reserved positions, and sparse post and clear masks often land on the same bit and on register-write cycles. The bench also walks the global enables through all eight combinations while one group holds an enabled pending source, which confirms the masking corner case.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  localparam int unsigned IRQ_W    = 12;
  localparam int unsigned CAUSE_W  = $clog2(IRQ_W);
  localparam int unsigned GROUP_SZ = 4;

  // Position within a group of four: 0 user, 1 supervisor, 2 reserved, 3 machine
  localparam int unsigned LVL_U   = 0;
  localparam int unsigned LVL_S   = 1;
  localparam int unsigned LVL_RSV = 2;
  localparam int unsigned LVL_M   = 3;

  function automatic logic [IRQ_W-1:0] lvlMask(input int unsigned lvl);
    logic [IRQ_W-1:0] m;
    m = '0;
    for (int i = 0; i < IRQ_W; i++) begin
      if ((i % GROUP_SZ) == lvl) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [IRQ_W-1:0] implMask();
    return ~lvlMask(LVL_RSV);
  endfunction

  localparam logic [IRQ_W-1:0] IMPL_MASK = implMask();

  function automatic logic [IRQ_W-1:0] globalMask(input logic u, input logic s,
                                                   input logic m);
    return ({IRQ_W{u}} & lvlMask(LVL_U)) |
           ({IRQ_W{s}} & lvlMask(LVL_S)) |
           ({IRQ_W{m}} & lvlMask(LVL_M));
  endfunction

  typedef struct packed {
    logic             pendLoad;
    logic [IRQ_W-1:0] pendLoadVal;
    logic             enLoad;
    logic [IRQ_W-1:0] enLoadVal;
    logic [IRQ_W-1:0] setBits;
    logic [IRQ_W-1:0] clrBits;
  } irq_cmd_t;
endpackage

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pend_pkg::*;
(
  input  logic [IRQ_W-1:0] postVec,
  input  logic [IRQ_W-1:0] clrVec,
  input  logic             clrAll,
  input  logic             pendWrEn,
  input  logic [IRQ_W-1:0] pendWrData,
  input  logic             enWrEn,
  input  logic [IRQ_W-1:0] enWrData,
  output irq_cmd_t         cmd
);
  always_comb begin
    cmd             = '0;
    cmd.pendLoad    = pendWrEn;
    cmd.pendLoadVal = pendWrData & IMPL_MASK;
    cmd.enLoad      = enWrEn;
    cmd.enLoadVal   = enWrData & IMPL_MASK;
    // Ordering: write, then clear (single or all), then post.
    cmd.clrBits     = (clrVec | {IRQ_W{clrAll}}) & IMPL_MASK;
    cmd.setBits     = postVec & IMPL_MASK;
  end
endmodule

// File: rtl/irq_pend_dp.sv
module irq_pend_dp
  import irq_pend_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  irq_cmd_t         cmd,
  output logic [IRQ_W-1:0] pendQ,
  output logic [IRQ_W-1:0] enQ
);
  logic [IRQ_W-1:0] pendBase;
  logic [IRQ_W-1:0] pendNext;
  logic [IRQ_W-1:0] enNext;

  always_comb begin
    pendBase = cmd.pendLoad ? cmd.pendLoadVal : pendQ;
    pendNext = (pendBase & ~cmd.clrBits) | cmd.setBits;
    enNext   = cmd.enLoad ? cmd.enLoadVal : enQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      enQ   <= '0;
    end else begin
      pendQ <= pendNext & IMPL_MASK;
      enQ   <= enNext & IMPL_MASK;
    end
  end
endmodule

// File: rtl/irq_pend_sel.sv
module irq_pend_sel
  import irq_pend_pkg::*;
(
  input  logic [IRQ_W-1:0]   pendQ,
  input  logic [IRQ_W-1:0]   enQ,
  input  logic               uGie,
  input  logic               sGie,
  input  logic               mGie,
  output logic               irqReq,
  output logic [CAUSE_W-1:0] irqCause
);
  logic [GROUP_SZ-1:0] gieByLvl;
  logic [IRQ_W-1:0]    ready;
  logic [IRQ_W-1:0]    hit;

  always_comb begin
    gieByLvl         = '0;
    gieByLvl[LVL_U]  = uGie;
    gieByLvl[LVL_S]  = sGie;
    gieByLvl[LVL_M]  = mGie;
  end

  for (genvar i = 0; i < IRQ_W; i++) begin : g_src
    assign ready[i] = pendQ[i] & enQ[i];
    assign hit[i]   = ready[i] & gieByLvl[i % GROUP_SZ];
  end

  always_comb begin
    irqCause = '0;
    for (int i = IRQ_W - 1; i >= 0; i--) begin
      if (hit[i]) irqCause = CAUSE_W'(i);
    end
  end

  assign irqReq = |hit;
endmodule

// File: rtl/irq_pend_unit.sv
module irq_pend_unit
  import irq_pend_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [IRQ_W-1:0]   postVec,
  input  logic [IRQ_W-1:0]   clrVec,
  input  logic               clrAll,
  input  logic               pendWrEn,
  input  logic [IRQ_W-1:0]   pendWrData,
  input  logic               enWrEn,
  input  logic [IRQ_W-1:0]   enWrData,
  input  logic               uGie,
  input  logic               sGie,
  input  logic               mGie,
  output logic [IRQ_W-1:0]   pendRd,
  output logic [IRQ_W-1:0]   enRd,
  output logic               irqReq,
  output logic [CAUSE_W-1:0] irqCause
);
  irq_cmd_t cmd;

  irq_pend_ctrl u_ctrl (
    .postVec(postVec), .clrVec(clrVec), .clrAll(clrAll),
    .pendWrEn(pendWrEn), .pendWrData(pendWrData),
    .enWrEn(enWrEn), .enWrData(enWrData), .cmd(cmd)
  );

  irq_pend_dp u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .pendQ(pendRd), .enQ(enRd)
  );

  irq_pend_sel u_sel (
    .pendQ(pendRd), .enQ(enRd), .uGie(uGie), .sGie(sGie), .mGie(mGie),
    .irqReq(irqReq), .irqCause(irqCause)
  );
endmodule

// File: rtl/irq_pend_chk.sv
module irq_pend_chk
  import irq_pend_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [IRQ_W-1:0]   postVec,
  input logic               clrAll,
  input logic               enWrEn,
  input logic               uGie,
  input logic               sGie,
  input logic               mGie,
  input logic [IRQ_W-1:0]   pendRd,
  input logic [IRQ_W-1:0]   enRd,
  input logic               irqReq,
  input logic [CAUSE_W-1:0] irqCause
);
  logic [IRQ_W-1:0] gm;
  assign gm = globalMask(uGie, sGie, mGie);

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    ((pendRd | enRd) & ~IMPL_MASK) == '0);

  a_r4_req_vs_vectors: assert property (@(posedge clk) disable iff (!rstN)
    irqReq == ((pendRd & enRd & gm) != '0));

  a_r5_cause_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !irqReq |-> irqCause == '0);

  a_r5_cause_is_live: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (pendRd[irqCause] && enRd[irqCause] && gm[irqCause]));

  a_r5_cause_lowest: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ((pendRd & enRd & gm & ((IRQ_W'(1) << irqCause) - IRQ_W'(1))) == '0));

  a_r6_post_sets: assert property (@(posedge clk) disable iff (!rstN)
    (postVec & IMPL_MASK) != '0 |=>
      (pendRd & $past(postVec & IMPL_MASK)) == $past(postVec & IMPL_MASK));

  a_r7_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    (clrAll && postVec == '0) |=> pendRd == '0);

  a_r8_enable_holds: assert property (@(posedge clk) disable iff (!rstN)
    !enWrEn |=> $stable(enRd));
endmodule

bind irq_pend_unit irq_pend_chk u_chk (
  .clk(clk), .rstN(rstN), .postVec(postVec), .clrAll(clrAll), .enWrEn(enWrEn),
  .uGie(uGie), .sGie(sGie), .mGie(mGie), .pendRd(pendRd), .enRd(enRd),
  .irqReq(irqReq), .irqCause(irqCause)
);

// File: tb/sim_irq_pend_unit.sv
`timescale 1ns/1ps
module sim_irq_pend_unit;
  localparam int W = 12;
  localparam logic [W-1:0] IMPL = 12'hBBB;
  localparam logic [W-1:0] GRP_U = 12'h111;
  localparam logic [W-1:0] GRP_S = 12'h222;
  localparam logic [W-1:0] GRP_M = 12'h888;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] postVec = '0, clrVec = '0, pendWrData = '0, enWrData = '0;
  logic clrAll = 1'b0, pendWrEn = 1'b0, enWrEn = 1'b0;
  logic uGie = 1'b0, sGie = 1'b0, mGie = 1'b0;
  logic [W-1:0] pendRd, enRd;
  logic irqReq;
  logic [3:0] irqCause;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [W-1:0] mPend = '0, mEn = '0;

  always #4 clk = ~clk;

  irq_pend_unit u0 (
    .clk(clk), .rstN(rstN), .postVec(postVec), .clrVec(clrVec), .clrAll(clrAll),
    .pendWrEn(pendWrEn), .pendWrData(pendWrData), .enWrEn(enWrEn), .enWrData(enWrData),
    .uGie(uGie), .sGie(sGie), .mGie(mGie),
    .pendRd(pendRd), .enRd(enRd), .irqReq(irqReq), .irqCause(irqCause)
  );

  function automatic logic [W-1:0] gmask(input logic u, input logic s, input logic m);
    return ({W{u}} & GRP_U) | ({W{s}} & GRP_S) | ({W{m}} & GRP_M);
  endfunction

  function automatic logic [3:0] expCause(input logic [W-1:0] live);
    for (int i = 0; i < W; i++) if (live[i]) return 4'(i);
    return 4'd0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic checkOut(input string tagPend);
    logic [W-1:0] live;
    live = mPend & mEn & gmask(uGie, sGie, mGie);
    chk(tagPend, int'(pendRd), int'(mPend));
    chk("R8 enable", int'(enRd), int'(mEn));
    chk("R4 request", int'(irqReq), int'(live != '0));
    chk("R5 cause", int'(irqCause), int'(expCause(live)));
  endtask

  // Drive one cycle of stimulus, let it take effect, then check.
  task automatic step(input logic [W-1:0] post, input logic [W-1:0] clr, input logic ca,
                      input logic pw, input logic [W-1:0] pd, input logic ew,
                      input logic [W-1:0] ed, input logic [2:0] gie, input string tag);
    @(negedge clk);
    postVec = post; clrVec = clr; clrAll = ca; pendWrEn = pw; pendWrData = pd;
    enWrEn = ew; enWrData = ed; {mGie, sGie, uGie} = gie;
    #1 checkOut("R4 pre-edge pending");
    @(posedge clk);
    if (pw) mPend = pd;
    if (ca) mPend = '0;
    mPend = ((mPend & ~clr) | post) & IMPL;
    if (ew) mEn = ed & IMPL;
    #1 checkOut(tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset pending", int'(pendRd), 0);
    chk("R1 reset enable", int'(enRd), 0);
    chk("R1 reset request", int'(irqReq), 0);
    @(negedge clk) rstN = 1'b1;

    // R2: reserved positions read zero after writes and posts
    step('0, '0, 0, 1, 12'hFFF, 1, 12'hFFF, 3'b000, "R2 write all ones");
    chk("R2 reserved pend", int'(pendRd & ~IMPL), 0);
    step(12'h444, '0, 0, 1, '0, 0, '0, 3'b000, "R2 post reserved");
    chk("R2 post reserved", int'(pendRd), 0);

    // R3/R9: each group alone, and disabled group never requests
    step(12'h888, '0, 0, 0, '0, 0, '0, 3'b011, "R9 machine masked");
    chk("R9 machine masked", int'(irqReq), 0);
    step('0, '0, 0, 0, '0, 0, '0, 3'b100, "R3 machine on");
    chk("R3 machine cause", int'(irqCause), 3);
    step(12'h222, 12'h888, 0, 0, '0, 0, '0, 3'b101, "R9 sup masked");
    chk("R9 sup masked", int'(irqReq), 0);
    step(12'h111, '0, 0, 0, '0, 0, '0, 3'b010, "R3 sup on");
    chk("R3 sup cause", int'(irqCause), 1);
    for (int g = 0; g < 8; g++) begin
      step('0, '0, 0, 1, 12'h111, 0, '0, 3'(g), "R9 user gie sweep");
      chk("R9 user gie sweep", int'(irqReq), int'(g[0]));
    end

    // R5: priority walk
    step('0, '0, 0, 1, 12'hBBB, 0, '0, 3'b111, "R5 all pending");
    chk("R5 lowest", int'(irqCause), 0);
    step('0, 12'h001, 0, 0, '0, 0, '0, 3'b111, "R5 after clear 0");
    chk("R5 next", int'(irqCause), 1);
    step('0, '0, 0, 0, '0, 0, '0, 3'b100, "R5 machine only");
    chk("R5 machine only", int'(irqCause), 3);
    step('0, '0, 0, 0, '0, 1, 12'h800, 3'b111, "R5 only bit 11 enabled");
    chk("R5 top bit", int'(irqCause), 11);

    // R6/R7/R8 collisions
    step(12'h010, 12'h010, 0, 0, '0, 0, '0, 3'b111, "R6 post beats clear");
    chk("R6 post beats clear", int'(pendRd[4]), 1);
    step(12'h200, '0, 1, 0, '0, 0, '0, 3'b111, "R7 clear all with post");
    chk("R7 survivor", int'(pendRd), 12'h200);
    step(12'h008, 12'h200, 0, 1, 12'h001, 0, '0, 3'b111, "R8 strobe after write");
    chk("R8 strobe wins", int'(pendRd), 12'h009);
    step('0, 12'h001, 0, 1, 12'h003, 0, '0, 3'b111, "R8 clear after write");
    chk("R8 clear wins", int'(pendRd), 12'h002);
    step('0, '0, 1, 0, '0, 0, '0, 3'b111, "R7 clear all");
    chk("R7 cleared", int'(pendRd), 0);

    // Constrained random
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] p, c, pd, ed;
      logic ca, pw, ew;
      p  = W'($urandom & $urandom & $urandom);
      c  = W'($urandom & $urandom & $urandom);
      ca = ($urandom % 16) == 0;
      pw = ($urandom % 8) == 0;
      ew = ($urandom % 8) == 0;
      pd = W'($urandom);
      ed = W'($urandom);
      step(p, c, ca, pw, pd, ew, ed, 3'($urandom), "R6 random pending");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule